// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a service line driven by a processor and raises an active-low watchdog flag when the line has shown no transition for a fixed number of clock cycles. A change in either direction counts as service. The service line is synchronised into the block's clock domain. A change is found by comparing each synchronised sample with the one before it. The clock period must therefore be shorter than the shortest service pulse the system produces. For example, detecting 50 ns pulses needs a clock faster than 20 MHz.

The timer is held at zero for as long as the reset generator reports reset active, and also while the enable input is low. The enable input takes the place of leaving the service pin unconnected. The flag is also forced low whenever the supply-ok input is low. It returns high in the same cycle that supply-ok returns, provided no timeout is pending. The flag can be looped back into the manual reset input of a reset generator. With the service line stuck, this produces a reset pulse once every timeout period plus recovery period. The default timeout is 80,000,000 cycles, which is 1.6 s at 50 MHz.

Top module: `edge_watchdog`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the timer is clear and `wdog_n` equals `supply_ok`.
- R2: With no service change and no hold, `wdog_n` goes low exactly `TIMEOUT_CYC` rising clock edges after the last edge that cleared the timer.
- R3: A rising or a falling change on `svc_in` restarts the timer. The restart happens at the `SYNC_STAGES+1`-th rising clock edge after the change, which is the third edge for the default of 2.
- R4: A service pulse that is high for a single clock cycle is seen as two changes, and each of them restarts the timer.
- R5: Once timed out, `wdog_n` stays low until a service change, a hold or a reset clears the timeout. It goes high right after the clock edge on which the change is recognised.
- R6: While `rst_active` is high the timer stays at zero and any timeout is cleared. Counting resumes on the first edge on which `rst_active` is low.
- R7: `wdog_n` is low in any cycle in which `supply_ok` is low, whatever the state of the timer. When `supply_ok` returns, `wdog_n` goes high in the same cycle unless a timeout is pending. Supply loss neither clears nor stops the timer.
- R8: While `wd_en` is low the timer is held at zero, the timeout is cleared and `wdog_n` follows `supply_ok`.
- R9: If `wdog_n` drives a reset generator that holds `rst_active` for a recovery time, and the service line is stuck, then falling edges of `wdog_n` repeat every `TIMEOUT_CYC` plus recovery cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_in | input | 1 | Asynchronous service line from the processor; either edge services the timer |
| rst_active | input | 1 | High while the system reset generator asserts reset |
| supply_ok | input | 1 | High while the supply is above its threshold |
| wd_en | input | 1 | Watchdog enable; low holds the timer clear |
| wdog_n | output | 1 | Active-low watchdog flag |

## Verification
The timeout and its release are due on a registered edge. A change on `svc_in` applied before rising edge k takes effect on the timer at edge k+2, and `rst_active` or `wd_en` sampled at an edge takes effect at that same edge. `wdog_n` therefore changes right after the edge that sets or clears the timeout. The exception is `supply_ok`, which acts on `wdog_n` in the same cycle. The bench applies each input at a falling edge and updates a reference at every rising edge. The reference is a count of edges since the last clearing event, with service changes seen through a three-sample history. It compares `wdog_n` at the following falling edge, so every cycle of each sweep is checked exactly where its result is due.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    // Nominal 1.6 s at a 50 MHz clock.
    localparam int unsigned DEF_TIMEOUT_CYC = 80_000_000;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,   // held clear by reset, disable or block reset
        ST_RUN  = 2'd1,   // counting idle cycles
        ST_TRIP = 2'd2    // timeout reached, waiting for service
    } wd_state_e;

    typedef struct packed {
        logic hold;   // force timer clear
        logic kick;   // service change recognised
    } wd_ctl_t;

    function automatic logic hold_req(input logic en, input logic rst_act);
        return rst_act | ~en;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdk_edge.sv
module wdk_edge (
    input  logic clk,
    input  logic rst,
    input  logic s,
    output logic kick
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= s;
    end

    // Either direction of change services the timer.
    assign kick = s ^ prev;
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer
    import wdk_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT_CYC
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_ctl_t ctl,
    output logic    timed_out
);
    localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    wd_state_e        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.hold) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else if (ctl.kick) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_HOLD, ST_RUN: begin
                    if (cnt == LAST) begin
                        state <= ST_TRIP;
                    end else begin
                        state <= ST_RUN;
                        cnt   <= cnt + CNT_W'(1);
                    end
                end
                ST_TRIP: state <= ST_TRIP;
                default: begin
                    state <= ST_HOLD;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign timed_out = (state == ST_TRIP);

    // R2
    trip_on_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_TRIP && cnt == LAST && !ctl.kick && !ctl.hold) |=> (state == ST_TRIP));

    // R3
    kick_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.kick && !ctl.hold) |=> (cnt == '0 && state == ST_RUN));

    // R5
    trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRIP && !ctl.kick && !ctl.hold) |=> (state == ST_TRIP));

    // R6
    hold_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.hold |=> (cnt == '0 && !timed_out));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
    import wdk_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT_CYC,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic svc_in,
    input  logic rst_active,
    input  logic supply_ok,
    input  logic wd_en,
    output logic wdog_n
);
    logic    svc_s;
    logic    kick;
    logic    tmo;
    wd_ctl_t ctl;

    wdk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (svc_in),
        .q   (svc_s)
    );

    wdk_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .s    (svc_s),
        .kick (kick)
    );

    always_comb begin
        ctl.hold = hold_req(wd_en, rst_active);
        ctl.kick = kick;
    end

    wdk_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .timed_out (tmo)
    );

    // Supply loss acts without delay in both directions.
    assign wdog_n = supply_ok & ~tmo;

    // R7
    supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(supply_ok) |-> !wdog_n);

    // R7
    supply_return_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(supply_ok) && !tmo) |-> wdog_n);

    // R8
    disable_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!wd_en && supply_ok) |=> (wdog_n || !supply_ok));
endmodule

// File: tb/edge_watchdog_tb.sv
module edge_watchdog_tb;
    localparam int unsigned T   = 16;
    localparam int unsigned REC = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic svc_in = 1'b0;
    logic rst_active = 1'b0;
    logic supply_ok = 1'b1;
    logic wd_en = 1'b1;
    logic wdog_n;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference state
    bit s1 = 0, s2 = 0, s3 = 0;
    int since = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    edge_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .svc_in(svc_in), .rst_active(rst_active),
        .supply_ok(supply_ok), .wd_en(wd_en), .wdog_n(wdog_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: wdog_n=%b expected %b", req, cyc, act, exp);
        end
    endtask

    // One clock: reference updated at the rising edge, output compared at the falling edge.
    task automatic step();
        bit k;
        @(posedge clk);
        cyc++;
        k = (s2 != s3);
        if (rst) begin
            s1 = 0; s2 = 0; s3 = 0; since = 0;
        end else begin
            s3 = s2; s2 = s1; s1 = svc_in;
            if (rst_active || !wd_en || k) since = 0;
            else if (since < T) since++;
        end
        @(negedge clk);
        check(tag, wdog_n, supply_ok && !(since >= int'(T)));
    endtask

    task automatic drive(input logic sv, input logic ra, input logic so, input logic en);
        svc_in = sv; rst_active = ra; supply_ok = so; wd_en = en;
        step();
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic lvl;
        int rec, last_fall, nfall;
        logic prev_wd;

        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        step();

        // R2: stuck line after reset
        tag = "R2";
        for (int i = 0; i < int'(T) + 6; i++) drive(1'b0, 1'b0, 1'b1, 1'b1);

        // R3/R5: toggle sweep over service periods, including periods beyond the timeout
        tag = "R3";
        lvl = 1'b0;
        for (int p = 1; p <= int'(T) + 4; p++) begin
            for (int c = 0; c < 3 * (int'(T) + 4); c++) begin
                if (c % p == 0) lvl = ~lvl;
                drive(lvl, 1'b0, 1'b1, 1'b1);
            end
        end

        // R5: timeout then hold stuck, then one change releases
        tag = "R5";
        for (int i = 0; i < int'(T) + 10; i++) drive(lvl, 1'b0, 1'b1, 1'b1);
        lvl = ~lvl;
        for (int i = 0; i < 6; i++) drive(lvl, 1'b0, 1'b1, 1'b1);

        // R4: single-cycle pulses with varying gaps
        tag = "R4";
        for (int g = 1; g <= int'(T) + 3; g++) begin
            drive(~lvl, 1'b0, 1'b1, 1'b1);
            for (int i = 0; i < g; i++) drive(lvl, 1'b0, 1'b1, 1'b1);
        end

        // R6: reset-active windows of several lengths, during count and after timeout
        tag = "R6";
        for (int w = 1; w <= 6; w++) begin
            for (int i = 0; i < int'(T) + w; i++) drive(lvl, 1'b0, 1'b1, 1'b1);
            for (int i = 0; i < w; i++) drive(lvl, 1'b1, 1'b1, 1'b1);
            for (int i = 0; i < int'(T) - w; i++) drive(lvl, 1'b0, 1'b1, 1'b1);
        end

        // R7: supply drops of several lengths at several points
        tag = "R7";
        for (int w = 1; w <= 8; w++) begin
            for (int i = 0; i < 2 * w + 3; i++) drive(lvl, 1'b0, 1'b1, 1'b1);
            for (int i = 0; i < w; i++) drive(lvl, 1'b0, 1'b0, 1'b1);
        end
        for (int i = 0; i < int'(T) + 4; i++) drive(lvl, 1'b0, (i % 3) != 0, 1'b1);

        // R8: disable windows, with supply changes and service changes inside
        tag = "R8";
        for (int w = 1; w <= 5; w++) begin
            for (int i = 0; i < int'(T) + 2; i++) drive(lvl, 1'b0, 1'b1, 1'b1);
            for (int i = 0; i < 3 * w; i++) begin
                if (i == w) lvl = ~lvl;
                drive(lvl, 1'b0, (i % 4) != 1, 1'b0);
            end
        end

        // R9: loopback to a reset generator with REC-cycle recovery
        tag = "R9";
        lvl = ~lvl;
        for (int i = 0; i < 4; i++) drive(lvl, 1'b0, 1'b1, 1'b1);
        rec = 0; last_fall = -1; nfall = 0; prev_wd = wdog_n;
        for (int i = 0; i < 5 * int'(T + REC); i++) begin
            drive(lvl, rec > 0, 1'b1, 1'b1);
            if (!wdog_n) rec = REC;
            else if (rec > 0) rec--;
            if (prev_wd && !wdog_n) begin
                if (last_fall >= 0) begin
                    checks++;
                    if (cyc - last_fall != int'(T + REC)) begin
                        errors++;
                        $display("FAIL R9 period actual %0d expected %0d", cyc - last_fall, T + REC);
                    end
                end
                last_fall = cyc;
                nfall++;
            end
            prev_wd = wdog_n;
        end
        checks++;
        if (nfall < 3) begin
            errors++;
            $display("FAIL R9 fall count actual %0d expected >= 3", nfall);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule